// File: doc/BRIEF.md
# SPI Register Port with Live Status

This block is a four-wire SPI slave for a register file. It sits between an external controller and a small bank of byte-wide registers. Every access is one 16-bit frame, sent while the active-low select is held low. The frame starts with a command byte, made of a direction flag and a 7-bit register address, and ends with one data byte. A write delivers the data byte to the register file. A read returns the addressed register on MISO during the data byte.

While the command byte is being shifted in, MISO carries a 7-bit status word. The status word gives PLL lock, FIFO overrun, FIFO underrun, FIFO full, FIFO empty and the two metadata bits of the head FIFO entry. This happens on writes as well as reads, so a controller that streams FIFO data learns the FIFO state without spending extra accesses on it.

The serial inputs are resampled in the system clock domain. SCLK is idle low (mode 0): the slave samples MOSI on the rising edge and updates MISO after the falling edge. The register-file side is a single-cycle strobe interface in the system clock domain.

Top module: `spi_status_regport`

## Requirements
- R1: After reset `reg_wr`, `reg_rd` and `spi_miso_oe` are low.
- R2: Frame bits travel most significant first. The first bit is the direction flag, where 1 means write and 0 means read. The next bits are address A6..A0, then data D7..D0.
- R3: On a write, exactly one single-cycle `reg_wr` pulse is issued, and only after the 16th rising SCLK edge. During that pulse `reg_addr` holds the frame address and `reg_wdata` holds the frame data byte.
- R4: On a read, one single-cycle `reg_rd` pulse is issued after the 8th rising SCLK edge, with `reg_addr` valid. `reg_rdata` is taken in that cycle, and MISO bit slots 8..15 return it MSB first.
- R5: MISO bit slot 0 is 0. Bit slots 1..7 carry the status, in this order: PLL lock, FIFO overrun, FIFO underrun, FIFO full, FIFO empty, head meta bit 1, head meta bit 0. This holds on reads and on writes.
- R6: The status is captured when select falls. Changes on the status inputs later in the same frame do not alter the bits shifted out.
- R7: MISO changes only after a falling SCLK edge (or select falling). It holds steady through the following rising edge.
- R8: `spi_miso_oe` is high only while select is low, allowing for the input synchronizer delay.
- R9: Raising select before the 16th bit cancels a write, so no `reg_wr` is issued. Raising it before the 8th bit also prevents any `reg_rd`.
- R10: A write frame never issues `reg_rd`, and it returns zeros in MISO bit slots 8..15.
- R11: SCLK edges beyond the 16th within one frame are ignored and issue no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | SPI select, active low |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from controller |
| spi_miso | output | 1 | Serial data to controller |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| pll_lock | input | 1 | Status: synthesizer locked |
| fifo_overrun | input | 1 | Status: FIFO overrun |
| fifo_underrun | input | 1 | Status: FIFO underrun |
| fifo_full | input | 1 | Status: FIFO full |
| fifo_empty | input | 1 | Status: FIFO empty |
| fifo_head_meta | input | 2 | Status: metadata bits of head FIFO entry |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | DATA_W | Read data, valid in the `reg_rd` cycle |

## Verification
The bench builds the block with its defaults: ADDR_W 7, DATA_W 8 and SYNC_STAGES 2. SCLK runs at one sixteenth of the system clock. With two synchronizer stages, the read fetch completes in the gap between the 8th rising edge and the 8th falling edge. Every status slot and data slot is therefore observable at its sampling point. These settings let the bench cover aborted frames at both cut points, overlong frames, and status inputs that change mid-frame, all at the edges of the 7-bit address and 8-bit data ranges.

// File: rtl/spi_status_regport.sv
module spi_status_regport #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sel_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              pll_lock,
  input  logic              fifo_overrun,
  input  logic              fifo_underrun,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [1:0]        fifo_head_meta,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int FRAME = 1 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int SW    = SYNC_STAGES + 1;
  localparam int SH_W  = (ADDR_W > DATA_W - 1) ? ADDR_W : DATA_W - 1;

  logic [SW-1:0]          sclk_p, sel_p;
  logic [SYNC_STAGES-1:0] mosi_p;
  logic [CNT_W-1:0]       cnt;
  logic [SH_W-1:0]        shreg;
  logic [FRAME-2:0]       out_sr;
  logic                   wr_flag, miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      sel_p  <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SW-2:0], spi_sclk};
      sel_p  <= {sel_p[SW-2:0], spi_sel_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
    end
  end

  wire sclk_rise = sclk_p[SW-2] & ~sclk_p[SW-1];
  wire sclk_fall = ~sclk_p[SW-2] & sclk_p[SW-1];
  wire sel_on    = ~sel_p[SW-2];
  wire sel_start = sel_on & sel_p[SW-1];
  wire mosi_s    = mosi_p[SYNC_STAGES-1];

  wire [6:0] status = {pll_lock, fifo_overrun, fifo_underrun, fifo_full,
                       fifo_empty, fifo_head_meta};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      out_sr    <= '0;
      wr_flag   <= 1'b0;
      miso_q    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (sel_start) begin
        cnt    <= '0;
        out_sr <= {ADDR_W'(status), {DATA_W{1'b0}}};
        miso_q <= 1'b0;
      end else if (sel_on) begin
        if (sclk_rise && cnt < CNT_W'(FRAME)) begin
          shreg <= {shreg[SH_W-2:0], mosi_s};
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(ADDR_W)) begin
            wr_flag  <= shreg[ADDR_W-1];
            reg_addr <= {shreg[ADDR_W-2:0], mosi_s};
            reg_rd   <= ~shreg[ADDR_W-1];
          end
          if (cnt == CNT_W'(FRAME - 1) && wr_flag) begin
            reg_wr    <= 1'b1;
            reg_wdata <= {shreg[DATA_W-2:0], mosi_s};
          end
        end
        if (sclk_fall && cnt != '0 && cnt < CNT_W'(FRAME)) begin
          miso_q <= out_sr[FRAME-2];
          out_sr <= {out_sr[FRAME-3:0], 1'b0};
        end
        if (reg_rd)
          out_sr[FRAME-2 -: DATA_W] <= reg_rdata;
      end
    end
  end

  assign spi_miso    = miso_q;
  assign spi_miso_oe = sel_on;

endmodule

module spi_status_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic reg_rd,
  input logic spi_miso,
  input logic spi_miso_oe,
  input logic sclk_fall,
  input logic sel_start
);

  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));

  assert_strobe_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> $past(spi_miso_oe));

  assert_miso_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && !$past(sclk_fall) && !$past(sel_start)) |-> $stable(spi_miso));

endmodule

bind spi_status_regport spi_status_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
  .sclk_fall(sclk_fall), .sel_start(sel_start)
);

// File: tb/spi_status_regport_bench.sv
module spi_status_regport_bench;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sclk = 0, mosi = 0;
  logic miso, miso_oe;
  logic [6:0] st = 7'h00;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic wr, rd;
  logic [7:0] mem [0:127];
  logic [7:0] exp_mem [0:127];
  logic [15:0] sb_q [$];
  int compared = 0, mismatched = 0, strobes = 0;

  always #2 clk = ~clk;

  spi_status_regport u_spi_status_regport (
    .clk(clk), .rst_n(rst_n), .spi_sel_n(sel_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .pll_lock(st[6]), .fifo_overrun(st[5]), .fifo_underrun(st[4]),
    .fifo_full(st[3]), .fifo_empty(st[2]), .fifo_head_meta(st[1:0]),
    .reg_addr(addr), .reg_wdata(wdata), .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata));

  assign rdata = mem[addr];

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected strobes {is_write, addr, data}
  always @(negedge clk) begin
    if (rst_n && (wr || rd)) begin
      logic [15:0] got;
      strobes++;
      got = {wr, addr, wr ? wdata : 8'h00};
      if (wr) mem[addr] = wdata;
      if (sb_q.size() == 0)
        check(1'b0, "R9 unexpected strobe", got, 16'hxxxx);
      else begin
        logic [15:0] e;
        e = sb_q.pop_front();
        check(got === e, "R3 R4 strobe", got, e);
      end
    end
  end

  task automatic xfer(input bit rw, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, input bit chg, input logic [6:0] st_new,
                      output logic [15:0] got, output bit hold_ok);
    logic [15:0] fr;
    fr = {rw, a, d};
    got = '0;
    hold_ok = 1;
    @(negedge clk) sel_n = 0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? fr[15-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i == 2 && chg) st = st_new;
      if (i < 16) got[15-i] = miso;
      sclk = 1;
      repeat (H) @(negedge clk);
      if (i < 16 && miso !== got[15-i]) hold_ok = 0;
      sclk = 0;
    end
    repeat (H) @(negedge clk);
    sel_n = 1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input int nb);
    logic [15:0] got, e;
    bit h;
    logic [6:0] s0;
    s0 = st;
    sb_q.push_back({1'b1, a, d});
    exp_mem[a] = d;
    xfer(1'b1, a, d, nb, 1'b0, 7'h0, got, h);
    e = {1'b0, s0, 8'h00};
    check(got === e, "R5 R10 write miso", got, e);
    check(h, "R7 miso hold", {15'h0, h}, 16'h1);
  endtask

  task automatic do_read(input logic [6:0] a, input bit chg, input logic [6:0] sn);
    logic [15:0] got, e;
    bit h;
    logic [6:0] s0;
    s0 = st;
    sb_q.push_back({1'b0, a, 8'h00});
    xfer(1'b0, a, 8'h5A, 16, chg, sn, got, h);
    e = {1'b0, s0, exp_mem[a]};
    check(got === e, chg ? "R6 latched status" : "R2 R4 R5 read miso", got, e);
    check(h, "R7 miso hold", {15'h0, h}, 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] g;
    bit h;
    int n0;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end
    repeat (3) @(negedge clk);
    check(wr === 0 && rd === 0 && miso_oe === 0, "R1 reset",
          {13'h0, wr, rd, miso_oe}, 16'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(miso_oe === 0, "R8 idle oe", {15'h0, miso_oe}, 16'h0);

    st = 7'b1010101;
    do_write(7'h12, 8'hA5, 16);
    st = 7'b0101010;
    do_read(7'h12, 1'b0, 7'h0);
    st = 7'b1111111;
    do_write(7'h7F, 8'hFF, 16);
    do_read(7'h7F, 1'b0, 7'h0);
    st = 7'b0000000;
    do_write(7'h00, 8'h00, 16);
    st = 7'b1000011;
    do_read(7'h00, 1'b0, 7'h0);
    st = 7'b0011100;
    do_read(7'h33, 1'b0, 7'h0);
    st = 7'b1100110;
    do_read(7'h41, 1'b1, 7'b0011001);

    n0 = strobes;
    xfer(1'b1, 7'h12, 8'h11, 12, 1'b0, 7'h0, g, h);
    check(strobes == n0, "R9 aborted write", 16'(strobes - n0), 16'h0);
    n0 = strobes;
    xfer(1'b0, 7'h12, 8'h00, 5, 1'b0, 7'h0, g, h);
    check(strobes == n0, "R9 aborted read", 16'(strobes - n0), 16'h0);
    do_read(7'h12, 1'b0, 7'h0);

    n0 = strobes;
    do_write(7'h2C, 8'h3C, 20);
    check(strobes == n0 + 1, "R11 extra clocks", 16'(strobes - n0), 16'h1);
    do_read(7'h2C, 1'b0, 7'h0);

    check(miso_oe === 0, "R8 oe after frames", {15'h0, miso_oe}, 16'h0);
    check(sb_q.size() == 0, "R3 R4 scoreboard drained", 16'(sb_q.size()), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule